// File: doc/BRIEF.md
# Pipelined Four-Bit Arithmetic and Logic Unit with Condition Flags

This block is a small clocked arithmetic and logic unit for a narrow datapath. On every clock edge it samples two operands, a carry-in bit and a four-bit operation code into source registers. On the following edge it writes the result computed from those registers into a destination register. The supported operations are addition through a chain of one-bit full adders, bitwise AND of both operands, and bitwise inversion of the first operand.

Along with the result, the block keeps an adder carry-out flag and three sign flags: negative, zero and positive. It also shows which operation is in progress as a one-hot vector decoded from the captured operation code. An operation code outside the three defined ones is a no-op: the result and all flags hold their values.

Operands flow in on every clock with no handshake. The surrounding logic is expected to hold or present a new operand set each cycle. An active-low reset clears every register at once, without waiting for a clock edge.

Top module: `nzp_alu_core`

## Requirements
- R1: With operation code 4'b0001 (add), the result equals the low WIDTH bits of first operand + second operand + carry-in, formed by a ripple chain in which the carry-in enters bit 0.
- R2: With operation code 4'b0101, the result is the bitwise AND of the two operands.
- R3: With operation code 4'b1001, the result is the bitwise inverse of the first operand, and the second operand and carry-in have no effect.
- R4: The carry flag takes the final carry of an add. An AND or invert operation clears it to 0.
- R5: After every result write, exactly one of the sign flags is set. Zero is set when every result bit is 0. Negative is set when the top result bit is 1. Positive is set otherwise.
- R6: Inputs present at clock edge k are captured into the source registers at edge k. Their result appears at the outputs only after edge k+1, and not after edge k.
- R7: Any operation code other than the three listed leaves the result, the carry flag and the sign flags unchanged.
- R8: The operation indicator is decoded from the captured operation code. Bit 0 marks add, bit 1 marks AND and bit 2 marks invert. All bits are 0 for any other code.
- R9: Driving reset low clears the result, all flags, the source registers and the operation indicator to zero immediately, without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| opa_i | input | WIDTH | First operand |
| opb_i | input | WIDTH | Second operand |
| cin_i | input | 1 | Adder carry-in |
| opc_i | input | 4 | Operation code |
| res_o | output | WIDTH | Destination register value |
| cout_o | output | 1 | Adder carry-out flag |
| neg_o | output | 1 | Result negative flag |
| zero_o | output | 1 | Result zero flag |
| pos_o | output | 1 | Result positive flag |
| op_o | output | 3 | One-hot operation in progress |

## Verification
The bench builds the block with its default WIDTH of 4. At that width every operand value is within reach of a short table, including the full-overflow case 15+15+1. That width also lets one table walk a wrap to zero with carry, a result with the top bit set, and a zero result for each operation. Directed steps after the table check that an unknown code holds a carry that was set by an earlier add. They also check that the result is not yet visible one edge after capture, and that reset clears everything between clock edges.

// File: rtl/alu4_pkg.sv
package alu4_pkg;
  localparam int OPC_W = 4;
  localparam int NOPS  = 3;

  localparam logic [OPC_W-1:0] OPC_ADD = 4'b0001;
  localparam logic [OPC_W-1:0] OPC_AND = 4'b0101;
  localparam logic [OPC_W-1:0] OPC_INV = 4'b1001;

  // one-hot operation select, op_add is bit 0
  typedef struct packed {
    logic op_inv;
    logic op_and;
    logic op_add;
  } op_sel_t;

  function automatic op_sel_t decode_opc(input logic [OPC_W-1:0] opc);
    op_sel_t s;
    s.op_add = (opc == OPC_ADD);
    s.op_and = (opc == OPC_AND);
    s.op_inv = (opc == OPC_INV);
    return s;
  endfunction
endpackage

// File: rtl/alu_src_stage.sv
module alu_src_stage
  import alu4_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] opa_i,
  input  logic [WIDTH-1:0] opb_i,
  input  logic             cin_i,
  input  logic [OPC_W-1:0] opc_i,
  output logic [WIDTH-1:0] sr1_o,
  output logic [WIDTH-1:0] sr2_o,
  output logic             cin_o,
  output logic [OPC_W-1:0] ir_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr1_o <= '0;
      sr2_o <= '0;
      cin_o <= 1'b0;
      ir_o  <= '0;
    end else begin
      sr1_o <= opa_i;
      sr2_o <= opb_i;
      cin_o <= cin_i;
      ir_o  <= opc_i;
    end
  end

  // R6: source registers follow the inputs of the previous edge
  assert_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (sr1_o == $past(opa_i) && ir_o == $past(opc_i)));
endmodule

// File: rtl/alu_ripple_add.sv
module alu_ripple_add #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  logic [WIDTH:0] carry;
  assign carry[0] = cin_i;

  for (genvar i = 0; i < WIDTH; i++) begin : g_fa
    assign sum_o[i]    = a_i[i] ^ b_i[i] ^ carry[i];
    assign carry[i+1]  = (a_i[i] & b_i[i]) | (carry[i] & (a_i[i] ^ b_i[i]));
  end

  assign cout_o = carry[WIDTH];
endmodule

// File: rtl/alu_exec.sv
module alu_exec
  import alu4_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] sr1_i,
  input  logic [WIDTH-1:0] sr2_i,
  input  logic             cin_i,
  input  op_sel_t          sel_i,
  output logic [WIDTH-1:0] res_o,
  output logic             carry_o,
  output logic             wr_o
);
  localparam int EXT_W = WIDTH + 1;

  logic [WIDTH-1:0] sum;
  logic             sum_co;

  alu_ripple_add #(.WIDTH(WIDTH)) u_add (
    .a_i   (sr1_i),
    .b_i   (sr2_i),
    .cin_i (cin_i),
    .sum_o (sum),
    .cout_o(sum_co)
  );

  always_comb begin
    res_o   = '0;
    carry_o = 1'b0;
    unique case (1'b1)
      sel_i.op_add: begin
        res_o   = sum;
        carry_o = sum_co;
      end
      sel_i.op_and: res_o = sr1_i & sr2_i;
      sel_i.op_inv: res_o = ~sr1_i;
      default: ;
    endcase
  end

  assign wr_o = |sel_i;

  // R1: ripple chain agrees with an arithmetic sum
  assert_ripple_sum_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sel_i.op_add |-> ({sum_co, sum} ==
      (EXT_W'(sr1_i) + EXT_W'(sr2_i) + EXT_W'(cin_i))));
  // R3: invert result does not depend on second operand
  assert_inv_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sel_i.op_inv |-> ((res_o ^ sr1_i) == {WIDTH{1'b1}}));
endmodule

// File: rtl/alu_dest_stage.sv
module alu_dest_stage #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [WIDTH-1:0] res_i,
  input  logic             carry_i,
  output logic [WIDTH-1:0] dr_o,
  output logic             cout_o,
  output logic             neg_o,
  output logic             zero_o,
  output logic             pos_o
);
  logic n_d, z_d;
  assign z_d = (res_i == '0);
  assign n_d = res_i[WIDTH-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dr_o   <= '0;
      cout_o <= 1'b0;
      neg_o  <= 1'b0;
      zero_o <= 1'b0;
      pos_o  <= 1'b0;
    end else if (wr_i) begin
      dr_o   <= res_i;
      cout_o <= carry_i;
      neg_o  <= n_d;
      zero_o <= z_d;
      pos_o  <= !n_d && !z_d;
    end
  end

  // R7: no write keeps everything
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> ($stable(dr_o) && $stable(cout_o) && $stable({neg_o, zero_o, pos_o})));
  // R5: exactly one sign flag after a write
  assert_one_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> ($countones({neg_o, zero_o, pos_o}) == 1));
  assert_zero_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    zero_o |-> (dr_o == '0));
  assert_neg_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    neg_o |-> dr_o[WIDTH-1]);
endmodule

// File: rtl/nzp_alu_core.sv
module nzp_alu_core
  import alu4_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] opa_i,
  input  logic [WIDTH-1:0] opb_i,
  input  logic             cin_i,
  input  logic [3:0]       opc_i,
  output logic [WIDTH-1:0] res_o,
  output logic             cout_o,
  output logic             neg_o,
  output logic             zero_o,
  output logic             pos_o,
  output logic [2:0]       op_o
);
  logic [WIDTH-1:0] sr1, sr2, alu_res;
  logic             sr_cin, alu_carry, alu_wr;
  logic [OPC_W-1:0] ir;
  op_sel_t          sel;

  alu_src_stage #(.WIDTH(WIDTH)) u_src (
    .clk  (clk),
    .rst_n(rst_n),
    .opa_i(opa_i),
    .opb_i(opb_i),
    .cin_i(cin_i),
    .opc_i(opc_i),
    .sr1_o(sr1),
    .sr2_o(sr2),
    .cin_o(sr_cin),
    .ir_o (ir)
  );

  assign sel  = decode_opc(ir);
  assign op_o = sel;

  alu_exec #(.WIDTH(WIDTH)) u_exec (
    .clk    (clk),
    .rst_n  (rst_n),
    .sr1_i  (sr1),
    .sr2_i  (sr2),
    .cin_i  (sr_cin),
    .sel_i  (sel),
    .res_o  (alu_res),
    .carry_o(alu_carry),
    .wr_o   (alu_wr)
  );

  alu_dest_stage #(.WIDTH(WIDTH)) u_dest (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_i   (alu_wr),
    .res_i  (alu_res),
    .carry_i(alu_carry),
    .dr_o   (res_o),
    .cout_o (cout_o),
    .neg_o  (neg_o),
    .zero_o (zero_o),
    .pos_o  (pos_o)
  );

  // R8: indicator never has two bits set
  assert_op_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(op_o));
  // R4: carry can only rise on an add cycle
  assert_carry_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cout_o) |-> $past(op_o[0]));
  // R4: AND or invert clears carry
  assert_carry_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_o[1] || op_o[2]) |=> !cout_o);
endmodule

// File: tb/nzp_alu_core_bench.sv
module nzp_alu_core_bench;
  localparam int W = 4;
  localparam int NV = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] opa = '0, opb = '0;
  logic         cin = 1'b0;
  logic [3:0]   opc = '0;
  logic [W-1:0] res;
  logic         cout, neg, zero, pos;
  logic [2:0]   op;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  nzp_alu_core #(.WIDTH(W)) u_nzp_alu_core (
    .clk(clk), .rst_n(rst_n), .opa_i(opa), .opb_i(opb), .cin_i(cin),
    .opc_i(opc), .res_o(res), .cout_o(cout), .neg_o(neg), .zero_o(zero),
    .pos_o(pos), .op_o(op)
  );

  // {a, b, cin, opc, expected result, expected carry}
  localparam logic [17:0] VEC [NV] = '{
    {4'h3, 4'h4, 1'b0, 4'h1, 4'h7, 1'b0},
    {4'h9, 4'h8, 1'b0, 4'h1, 4'h1, 1'b1},
    {4'hC, 4'hA, 1'b0, 4'h5, 4'h8, 1'b0},
    {4'hF, 4'h0, 1'b1, 4'h1, 4'h0, 1'b1},
    {4'h6, 4'hF, 1'b1, 4'h9, 4'h9, 1'b0},
    {4'h5, 4'h2, 1'b1, 4'h1, 4'h8, 1'b0},
    {4'h3, 4'hC, 1'b0, 4'h5, 4'h0, 1'b0},
    {4'hF, 4'h3, 1'b1, 4'h9, 4'h0, 1'b0},
    {4'hF, 4'hF, 1'b1, 4'h1, 4'hF, 1'b1},
    {4'h8, 4'h0, 1'b0, 4'h9, 4'h7, 1'b0}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_op(input logic [3:0] c);
    return (c == 4'h1) ? 3'b001 : (c == 4'h5) ? 3'b010 : (c == 4'h9) ? 3'b100 : 3'b000;
  endfunction

  // flags {n,z,p} from the result per R5
  function automatic logic [2:0] exp_flags(input logic [W-1:0] r);
    logic n, z;
    n = r[W-1];
    z = (r == '0);
    return {n, z, !n && !z};
  endfunction

  task automatic drive(input logic [3:0] a, input logic [3:0] b,
                       input logic c, input logic [3:0] o);
    @(negedge clk);
    opa = a; opb = b; cin = c; opc = o;
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    // R9 reset state
    chk("R9 reset res", 8'(res), 8'h0);
    chk("R9 reset flags", 8'({cout, neg, zero, pos}), 8'h0);
    chk("R9 reset op", 8'(op), 8'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [17:0] v;
      v = VEC[i];
      drive(v[17:14], v[13:10], v[9], v[8:5]);
      @(posedge clk); #1;
      chk("R8 op indicator", 8'(op), 8'(exp_op(v[8:5])));
      @(posedge clk); @(negedge clk);
      chk(v[8:5] == 4'h1 ? "R1 add result" : v[8:5] == 4'h5 ? "R2 and result" : "R3 inv result",
          8'(res), 8'(v[4:1]));
      chk("R4 carry", 8'(cout), 8'(v[0]));
      chk("R5 flags", 8'({neg, zero, pos}), 8'(exp_flags(v[4:1])));
    end

    // R7: unknown code holds result and a set carry
    drive(4'h9, 4'h8, 1'b0, 4'h1);
    @(posedge clk); @(posedge clk);
    drive(4'hF, 4'hF, 1'b1, 4'hD);
    @(posedge clk); #1;
    chk("R8 unknown code op", 8'(op), 8'h0);
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R7 hold res", 8'(res), 8'h1);
    chk("R7 hold carry", 8'(cout), 8'h1);
    chk("R7 hold flags", 8'({neg, zero, pos}), 8'b001);
    drive(4'h2, 4'h2, 1'b0, 4'h0);
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R7 code 0 hold", 8'(res), 8'h1);

    // R6: result not visible one edge after capture
    drive(4'h2, 4'h3, 1'b0, 4'h1);
    @(posedge clk); #1;
    chk("R6 not yet", 8'(res), 8'h1);
    @(posedge clk); #1;
    chk("R6 after two edges", 8'(res), 8'h5);
    chk("R6 carry", 8'(cout), 8'h0);

    // R3: second operand and carry-in ignored by invert
    drive(4'h5, 4'hF, 1'b1, 4'h9);
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R3 inv ignores b", 8'(res), 8'hA);

    // R9: asynchronous reset between edges
    @(negedge clk); #1;
    rst_n = 1'b0;
    #0.5;
    chk("R9 async res", 8'(res), 8'h0);
    chk("R9 async flags", 8'({cout, neg, zero, pos}), 8'h0);
    chk("R9 async op", 8'(op), 8'h0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule